// File: doc/BRIEF.md
# Wake-on-LAN Event Detector

This block sits beside the receive path of an Ethernet MAC and watches every incoming frame for one of four wake-up conditions: a magic packet addressed to this station, an ARP request for the station's IP address, a hit in the first specific-address filter, and a hit in the multicast hash filter. The three filter conditions arrive as one-cycle strobes from neighbouring filter logic. The magic packet is recognised inside the block from the received byte stream.

When an enabled condition fires, the block drives a wake pulse of fixed length, counted in receive clocks. Power-management logic uses this pulse to bring the system out of a low-power state. A master receive enable gates all detection. No receive buffer needs to be available for a wake to occur.

Frames are presented one byte per cycle. `rx_sof` marks the first byte. A separate end cycle carries `rx_eof`, and the frame's error status is sampled on that cycle.

Top module: `wake_event_detector`

## Requirements
- R1: While `rst_n` is low, `wake_pulse` is 0. Reset discards all detection state, so a frame that was partly received before reset cannot produce a magic-packet wake after reset. A pulse in progress ends at once.
- R2: An event sampled at a rising clock edge makes `wake_pulse` high from the following cycle for exactly `PULSE_LEN` cycles (64 by default).
- R3: While `rx_enable` is 0, no event of any kind starts a pulse.
- R4: `wake_en` enables each event separately. Bit 0 enables the magic packet, bit 1 the ARP request, bit 2 the specific-address match, and bit 3 the multicast hash match. An event whose bit is 0 has no effect.
- R5: ARP, specific-address and hash strobes start a pulse in the same cycle they arrive, even on a cycle where `rx_eof` and `rx_err` are both 1.
- R6: A magic packet produces no wake when `rx_err` is 1 on its end cycle.
- R7: A magic packet needs its first six bytes (the destination address) to equal `station_addr`, sent most significant byte first (`station_addr[47:40]` first). A frame that differs in any of these bytes produces no wake.
- R8: The address copies of a magic packet must follow a run of at least `SYNC_LEN` (6) consecutive 0xFF bytes. A run of five is rejected. A longer run is accepted.
- R9: After the sync run, the six-byte station address must appear `REPEATS` (16) times back to back. Fifteen copies are rejected. Extra copies or trailing bytes after the sixteenth copy still count as a match.
- R10: A magic packet is decided only on the frame's end cycle. `wake_pulse` stays 0 through all data bytes and rises in the cycle after the `rx_eof` cycle.
- R11: A new event during an active pulse restarts the count, so the pulse then lasts `PULSE_LEN` cycles from the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | With `rx_valid`: this byte is the first of a frame |
| rx_eof | input | 1 | End-of-frame cycle (carries no byte) |
| rx_err | input | 1 | Frame error status, sampled with `rx_eof` |
| arp_req_hit | input | 1 | Strobe: ARP request for the station IP seen |
| addr_filt_hit | input | 1 | Strobe: specific address filter 1 matched |
| hash_filt_hit | input | 1 | Strobe: multicast hash filter matched |
| wake_en | input | 4 | Per-event enables (magic, ARP, address, hash) |
| rx_enable | input | 1 | Master receive enable |
| station_addr | input | 48 | Station MAC address, first byte in [47:40] |
| wake_pulse | output | 1 | Wake output pulse |

## Verification
The hardest condition to reach from the ports is a near-miss magic packet. Such a frame looks correct at every byte boundary but fails on one count: a sync run one byte short, one address copy too few, or a destination that is wrong in one byte. The stimulus therefore builds each frame from a parameterised generator, with the sync length, the copy count, the destination and the end status as arguments. Runs just below and just above each threshold go through the same path. Restart of the pulse is checked by a second strobe placed partway through a live pulse, after which the remaining width is measured.

// File: rtl/wol_pkg.sv
package wol_pkg;

  localparam int MAC_BYTES = 6;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;

  // wake_en bit positions
  localparam int EN_MAGIC = 0;
  localparam int EN_ARP   = 1;
  localparam int EN_ADDR  = 2;
  localparam int EN_HASH  = 3;

  typedef enum logic {SCAN_SYNC, SCAN_ADDR} scan_state_e;

  // Byte idx of a MAC address in wire order (idx 0 = bits [47:40])
  function automatic logic [7:0] mac_byte(input logic [47:0] mac, input logic [2:0] idx);
    logic [47:0] shifted;
    shifted = mac >> (8 * (MAC_BYTES - 1 - int'(idx)));
    return shifted[7:0];
  endfunction

  // Down-counter step of the pulse timer
  function automatic logic [15:0] pulse_step(input logic [15:0] cur, input logic load,
                                             input logic [15:0] len);
    if (load) return len;
    if (cur != 16'd0) return cur - 16'd1;
    return 16'd0;
  endfunction

endpackage

// File: rtl/wol_dest_match.sv
module wol_dest_match
  import wol_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        byte_sof,
  input  logic [7:0]  byte_dat,
  input  logic        frame_end,
  input  logic [47:0] station,
  output logic        frame_open,
  output logic        dest_hit
);

  localparam logic [2:0] LAST_POS = 3'(MAC_BYTES);

  logic [2:0] pos_q;
  logic       same_q;
  logic       open_q;
  logic       byte_ok;

  assign byte_ok = (byte_dat == mac_byte(station, byte_sof ? 3'd0 : pos_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      same_q <= 1'b0;
      open_q <= 1'b0;
    end else if (frame_end) begin
      open_q <= 1'b0;
    end else if (byte_vld && byte_sof) begin
      open_q <= 1'b1;
      pos_q  <= 3'd1;
      same_q <= byte_ok;
    end else if (byte_vld && open_q && pos_q < LAST_POS) begin
      pos_q  <= pos_q + 3'd1;
      same_q <= same_q & byte_ok;
    end
  end

  assign frame_open = open_q;
  assign dest_hit   = same_q && (pos_q == LAST_POS);

  AST_CLOSED_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_open); // R10

  AST_DEST_NEEDS_SIX: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_sof) |=> !dest_hit); // R7

endmodule

// File: rtl/wol_magic_scan.sv
module wol_magic_scan
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 6,
  parameter int unsigned REPEATS  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        byte_sof,
  input  logic [7:0]  byte_dat,
  input  logic [47:0] station,
  output logic        magic_seen
);

  localparam int unsigned FF_W  = $clog2(SYNC_LEN + 1);
  localparam int unsigned REP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [FF_W-1:0]  FF_FULL  = FF_W'(SYNC_LEN);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);
  localparam logic [2:0]       IDX_LAST = 3'(MAC_BYTES - 1);

  scan_state_e      st_q, st_c, st_n;
  logic [FF_W-1:0]  ff_q, ff_c, ff_n;
  logic [REP_W-1:0] rep_q, rep_c, rep_n;
  logic [2:0]       idx_q, idx_c, idx_n;
  logic             seen_q, seen_c, seen_n;
  logic             is_sync_byte;
  logic             addr_byte_ok;

  // A start-of-frame byte is scanned from a fresh state
  always_comb begin
    st_c   = byte_sof ? SCAN_SYNC : st_q;
    ff_c   = byte_sof ? '0 : ff_q;
    rep_c  = byte_sof ? '0 : rep_q;
    idx_c  = byte_sof ? 3'd0 : idx_q;
    seen_c = byte_sof ? 1'b0 : seen_q;
  end

  assign is_sync_byte = (byte_dat == SYNC_BYTE);
  assign addr_byte_ok = (byte_dat == mac_byte(station, (st_c == SCAN_ADDR) ? idx_c : 3'd0));

  always_comb begin
    st_n   = st_c;
    ff_n   = ff_c;
    rep_n  = rep_c;
    idx_n  = idx_c;
    seen_n = seen_c;
    unique case (st_c)
      SCAN_SYNC: begin
        if (is_sync_byte) begin
          ff_n = (ff_c == FF_FULL) ? FF_FULL : ff_c + 1'b1;
        end else if (ff_c == FF_FULL && addr_byte_ok) begin
          st_n  = SCAN_ADDR;
          idx_n = 3'd1;
          rep_n = '0;
          ff_n  = '0;
        end else begin
          ff_n = '0;
        end
      end
      SCAN_ADDR: begin
        if (addr_byte_ok) begin
          if (idx_c == IDX_LAST) begin
            idx_n = 3'd0;
            if (rep_c == REP_LAST) begin
              seen_n = 1'b1;
              st_n   = SCAN_SYNC;
              rep_n  = '0;
            end else begin
              rep_n = rep_c + 1'b1;
            end
          end else begin
            idx_n = idx_c + 3'd1;
          end
        end else begin
          st_n  = SCAN_SYNC;
          idx_n = 3'd0;
          rep_n = '0;
          ff_n  = is_sync_byte ? FF_W'(1) : '0;
        end
      end
      default: st_n = SCAN_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_SYNC;
      ff_q   <= '0;
      rep_q  <= '0;
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else if (byte_vld) begin
      st_q   <= st_n;
      ff_q   <= ff_n;
      rep_q  <= rep_n;
      idx_q  <= idx_n;
      seen_q <= seen_n;
    end
  end

  assign magic_seen = seen_q;

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (magic_seen && !(byte_vld && byte_sof)) |=> magic_seen); // R9

  AST_SOF_CLEARS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_sof) |=> !magic_seen); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(magic_seen)); // R10

endmodule

// File: rtl/wol_pulse_timer.sv
module wol_pulse_timer
  import wol_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [15:0] LOAD16 = 16'(PULSE_LEN);

  logic [CNT_W-1:0] remain_q;
  logic [15:0]      step_w;

  assign step_w = pulse_step(16'(remain_q), fire, LOAD16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else        remain_q <= step_w[CNT_W-1:0];
  end

  assign pulse = (remain_q != '0);

  AST_RELOAD_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (remain_q == CNT_W'(PULSE_LEN))); // R11

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && pulse) |=> (remain_q == $past(remain_q) - 1'b1)); // R2

endmodule

// File: rtl/wake_event_detector.sv
module wake_event_detector
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN  = 6,
  parameter int unsigned REPEATS   = 16,
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic        clk_rx,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic        arp_req_hit,
  input  logic        addr_filt_hit,
  input  logic        hash_filt_hit,
  input  logic [3:0]  wake_en,
  input  logic        rx_enable,
  input  logic [47:0] station_addr,
  output logic        wake_pulse
);

  logic frame_open;
  logic dest_hit;
  logic magic_seen;
  logic clean_end;
  logic magic_evt;
  logic strobe_evt;
  logic any_evt;

  wol_dest_match u_dest (
    .clk        (clk_rx),
    .rst_n      (rst_n),
    .byte_vld   (rx_valid),
    .byte_sof   (rx_sof),
    .byte_dat   (rx_data),
    .frame_end  (rx_eof),
    .station    (station_addr),
    .frame_open (frame_open),
    .dest_hit   (dest_hit)
  );

  wol_magic_scan #(
    .SYNC_LEN (SYNC_LEN),
    .REPEATS  (REPEATS)
  ) u_scan (
    .clk        (clk_rx),
    .rst_n      (rst_n),
    .byte_vld   (rx_valid),
    .byte_sof   (rx_sof),
    .byte_dat   (rx_data),
    .station    (station_addr),
    .magic_seen (magic_seen)
  );

  // Magic packet is judged on the end cycle; strobes act at once
  assign clean_end  = rx_eof && !rx_err && frame_open;
  assign magic_evt  = rx_enable && wake_en[EN_MAGIC] && clean_end && dest_hit && magic_seen;
  assign strobe_evt = rx_enable && ((arp_req_hit   && wake_en[EN_ARP])  ||
                                    (addr_filt_hit && wake_en[EN_ADDR]) ||
                                    (hash_filt_hit && wake_en[EN_HASH]));
  assign any_evt    = magic_evt || strobe_evt;

  wol_pulse_timer #(
    .PULSE_LEN (PULSE_LEN)
  ) u_timer (
    .clk   (clk_rx),
    .rst_n (rst_n),
    .fire  (any_evt),
    .pulse (wake_pulse)
  );

  // Pulse-width observer used only by the assertions
  localparam int unsigned RUN_W = $clog2(PULSE_LEN + 1) + 1;
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk_rx or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (any_evt)    run_len <= '0;
    else if (wake_pulse) run_len <= run_len + 1'b1;
  end

  AST_EVENT_WAKES: assert property (@(posedge clk_rx) disable iff (!rst_n)
    any_evt |=> wake_pulse); // R2

  AST_PULSE_WIDTH: assert property (@(posedge clk_rx) disable iff (!rst_n)
    $fell(wake_pulse) |-> (run_len == RUN_W'(PULSE_LEN))); // R2

  AST_RX_OFF_QUIET: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (!rx_enable && !wake_pulse) |=> !wake_pulse); // R3

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_rx) disable iff (!rst_n)
    ((wake_en == 4'b0000) && !wake_pulse) |=> !wake_pulse); // R4

  AST_NO_MAGIC_MIDFRAME: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (!rx_eof && !strobe_evt && !wake_pulse) |=> !wake_pulse); // R10

endmodule

// File: tb/test_wake_event_detector.sv
module test_wake_event_detector;

  localparam logic [47:0] STATION = 48'h02_1A_2B_3C_4D_5E;
  localparam int PULSE = 64;

  logic        clk_rx = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_sof = 1'b0;
  logic        rx_eof = 1'b0;
  logic        rx_err = 1'b0;
  logic        arp_req_hit = 1'b0;
  logic        addr_filt_hit = 1'b0;
  logic        hash_filt_hit = 1'b0;
  logic [3:0]  wake_en = 4'hF;
  logic        rx_enable = 1'b1;
  logic [47:0] station_addr = STATION;
  logic        wake_pulse;

  int checks = 0;
  int errors = 0;

  wake_event_detector i_wake_event_detector (
    .clk_rx        (clk_rx),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_sof        (rx_sof),
    .rx_eof        (rx_eof),
    .rx_err        (rx_err),
    .arp_req_hit   (arp_req_hit),
    .addr_filt_hit (addr_filt_hit),
    .hash_filt_hit (hash_filt_hit),
    .wake_en       (wake_en),
    .rx_enable     (rx_enable),
    .station_addr  (station_addr),
    .wake_pulse    (wake_pulse)
  );

  always #10 clk_rx = ~clk_rx;

  initial begin
    repeat (200000) @(posedge clk_rx);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [7:0] sta_byte(input int k);
    return STATION[8*(5-k) +: 8];
  endfunction

  task automatic do_reset();
    @(negedge clk_rx);
    rst_n = 1'b0;
    repeat (2) @(negedge clk_rx);
    rst_n = 1'b1;
    @(negedge clk_rx);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit first);
    rx_valid = 1'b1;
    rx_data  = b;
    rx_sof   = first;
    @(negedge clk_rx);
    rx_valid = 1'b0;
    rx_sof   = 1'b0;
  endtask

  task automatic send_body(input bit dest_good, input int nff, input int nrep);
    for (int k = 0; k < 6; k++)
      send_byte((k == 5 && !dest_good) ? (sta_byte(k) ^ 8'h01) : sta_byte(k), k == 0);
    for (int k = 0; k < 6; k++) send_byte(8'hA0 + 8'(k), 1'b0);
    send_byte(8'h08, 1'b0);
    send_byte(8'h42, 1'b0);
    for (int k = 0; k < nff; k++) send_byte(8'hFF, 1'b0);
    for (int r = 0; r < nrep; r++)
      for (int k = 0; k < 6; k++) send_byte(sta_byte(k), 1'b0);
    for (int k = 0; k < 4; k++) send_byte(8'h11, 1'b0);
  endtask

  // End cycle; wake must still be low before it (R10)
  task automatic end_frame(input bit err);
    check(wake_pulse == 1'b0, "R10 no wake before end cycle", int'(wake_pulse), 0);
    rx_eof = 1'b1;
    rx_err = err;
    @(negedge clk_rx);
    rx_eof = 1'b0;
    rx_err = 1'b0;
  endtask

  task automatic expect_pulse(input string req);
    int n = 0;
    while (wake_pulse && n < 200) begin
      n++;
      @(negedge clk_rx);
    end
    check(n == PULSE, req, n, PULSE);
  endtask

  task automatic expect_quiet(input string req);
    int highs = 0;
    repeat (80) begin
      if (wake_pulse) highs++;
      @(negedge clk_rx);
    end
    check(highs == 0, req, highs, 0);
  endtask

  task automatic pulse_strobe(input int which);
    case (which)
      1: arp_req_hit   = 1'b1;
      2: addr_filt_hit = 1'b1;
      default: hash_filt_hit = 1'b1;
    endcase
    @(negedge clk_rx);
    arp_req_hit   = 1'b0;
    addr_filt_hit = 1'b0;
    hash_filt_hit = 1'b0;
  endtask

  task automatic t_reset_state();
    check(wake_pulse == 1'b0, "R1 wake low after reset", int'(wake_pulse), 0);
  endtask

  task automatic t_magic_good();
    send_body(1'b1, 6, 16);
    end_frame(1'b0);
    expect_pulse("R2 magic packet pulse width");
  endtask

  task automatic t_magic_errored();
    send_body(1'b1, 6, 16);
    end_frame(1'b1);
    expect_quiet("R6 errored magic packet ignored");
  endtask

  task automatic t_magic_bad_dest();
    send_body(1'b0, 6, 16);
    end_frame(1'b0);
    expect_quiet("R7 wrong destination ignored");
  endtask

  task automatic t_sync_len();
    send_body(1'b1, 5, 16);
    end_frame(1'b0);
    expect_quiet("R8 five sync bytes rejected");
    send_body(1'b1, 9, 16);
    end_frame(1'b0);
    expect_pulse("R8 long sync run accepted");
  endtask

  task automatic t_repeats();
    send_body(1'b1, 6, 15);
    end_frame(1'b0);
    expect_quiet("R9 fifteen copies rejected");
    send_body(1'b1, 6, 17);
    end_frame(1'b0);
    expect_pulse("R9 seventeen copies accepted");
  endtask

  task automatic t_enables();
    wake_en = 4'b1110;
    send_body(1'b1, 6, 16);
    end_frame(1'b0);
    expect_quiet("R4 magic masked by bit 0");
    for (int s = 1; s <= 3; s++) begin
      wake_en = 4'b0001 | 4'(1 << s);
      pulse_strobe(s);
      expect_pulse("R4 strobe with its own bit enabled");
      wake_en = ~(4'(1 << s));
      pulse_strobe(s);
      expect_quiet("R4 strobe with its own bit cleared");
    end
    wake_en = 4'hF;
  endtask

  task automatic t_rx_disabled();
    rx_enable = 1'b0;
    send_body(1'b1, 6, 16);
    end_frame(1'b0);
    expect_quiet("R3 magic ignored when receive disabled");
    pulse_strobe(1);
    pulse_strobe(2);
    pulse_strobe(3);
    expect_quiet("R3 strobes ignored when receive disabled");
    rx_enable = 1'b1;
  endtask

  task automatic t_strobe_on_error();
    rx_eof = 1'b1;
    rx_err = 1'b1;
    hash_filt_hit = 1'b1;
    @(negedge clk_rx);
    rx_eof = 1'b0;
    rx_err = 1'b0;
    hash_filt_hit = 1'b0;
    expect_pulse("R5 hash strobe wakes on errored frame");
  endtask

  task automatic t_retrigger();
    pulse_strobe(2);
    repeat (30) @(negedge clk_rx);
    check(wake_pulse == 1'b1, "R11 pulse live before retrigger", int'(wake_pulse), 1);
    pulse_strobe(1);
    expect_pulse("R11 retrigger restarts full width");
  endtask

  task automatic t_reset_midway();
    send_body(1'b1, 6, 16);
    do_reset();
    end_frame(1'b0);
    expect_quiet("R1 partial frame state cleared by reset");
    pulse_strobe(3);
    repeat (5) @(negedge clk_rx);
    rst_n = 1'b0;
    @(negedge clk_rx);
    check(wake_pulse == 1'b0, "R1 reset ends pulse", int'(wake_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk_rx);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_magic_good();
    t_magic_errored();
    t_magic_bad_dest();
    t_sync_len();
    t_repeats();
    t_enables();
    t_rx_disabled();
    t_strobe_on_error();
    t_retrigger();
    t_reset_midway();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule